// File: doc/BRIEF.md
# PCIe MSI Capture Interrupt Controller

This block sits beside a root port and turns message-signalled interrupts into one level interrupt line. Software programs a 64-bit doorbell address through a small 32-bit register port, opens individual vectors with an enable register and silences them with a separate mask register. Inbound posted memory writes are snooped. A 4-byte write that hits the doorbell address carries a vector number N in its data. If vector N is enabled, the write latches status bit N.

The interrupt line stays high while any latched status bit is unmasked. Software reads status and clears the bits it has handled by writing ones to them. One group of up to 32 vectors is held. A doorbell that sets a bit in the same cycle as software clears that bit takes precedence, so no interrupt is lost.

Top module: `msi_catcher`

## Requirements
- R1: Register offsets on `reg_addr`: 0x820 doorbell address bits 31:0, 0x824 doorbell address bits 63:32, 0x828 vector enable, 0x82C vector mask, 0x830 status. A read returns the current value on `reg_rdata` one clock after `reg_rd_en`. Any other offset reads as zero.
- R2: Writing either half of the doorbell address leaves the other half unchanged.
- R3: A snooped write with `snoop_addr` equal to the doorbell address, `snoop_len` = 4 and data N < 32 sets status bit N when enable bit N is 1. When enable bit N is 0, the status is unchanged.
- R4: `irq_o` is 1 exactly while (status AND NOT mask) is nonzero. The mask does not stop status bits being latched.
- R5: Writing the status register clears every status bit whose data bit is 1 (write-one-to-clear). Once the status is all zero, `irq_o` is 0.
- R6: While the enable register is all zero, doorbell writes change nothing.
- R7: A snooped write with `snoop_len` other than 4 changes nothing.
- R8: Doorbell data values of 32 or more set no status bit.
- R9: If a doorbell sets a bit in the same cycle as a status write clears it, the bit ends up set. Other cleared bits are still cleared in that cycle.
- R10: After reset, all five registers read as zero and `irq_o` is 0.
- R11: A snooped write to any address other than the doorbell address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one clock after the read strobe |
| snoop_valid | input | 1 | A posted memory write is present on the snoop inputs |
| snoop_addr | input | 64 | Snooped write address |
| snoop_data | input | 32 | Snooped write data (vector number) |
| snoop_len | input | 3 | Snooped write size in bytes |
| irq_o | output | 1 | Level interrupt: an unmasked vector is pending |

## Verification
A register write or a doorbell takes effect at the clock edge that samples it. The bench therefore checks `irq_o` at the falling edge that follows that strobe, with no extra latency. Read data is registered and is due one edge after the read strobe. The scoreboard queues each expected read value when the read is issued, and the monitor pops it at the falling edge after the sampling edge. Expected values come from a bench-side model of the registers that is updated from the requirements as each stimulus is driven.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int REG_AW  = 12;
  localparam int REG_DW  = 32;
  localparam int TGT_AW  = 64;

  localparam logic [REG_AW-1:0] OFF_TGT_LO = 12'h820;
  localparam logic [REG_AW-1:0] OFF_TGT_HI = 12'h824;
  localparam logic [REG_AW-1:0] OFF_ENABLE = 12'h828;
  localparam logic [REG_AW-1:0] OFF_MASK   = 12'h82C;
  localparam logic [REG_AW-1:0] OFF_STATUS = 12'h830;

  function automatic logic is_doorbell_size(input logic [2:0] len, input int bytes);
    return len == 3'(bytes);
  endfunction
endpackage

// File: rtl/msi_regfile.sv
module msi_regfile
  import msi_pkg::*;
#(
  parameter int NVEC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic [NVEC-1:0]   status,
  output logic [TGT_AW-1:0] tgt_addr,
  output logic [NVEC-1:0]   enable,
  output logic [NVEC-1:0]   mask,
  output logic [NVEC-1:0]   clr_vec,
  output logic [REG_DW-1:0] rdata
);
  logic [REG_DW-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr <= '0;
      enable   <= '0;
      mask     <= '0;
    end else if (wr_en) begin
      case (addr)
        OFF_TGT_LO: tgt_addr[31:0]  <= wdata;
        OFF_TGT_HI: tgt_addr[63:32] <= wdata;
        OFF_ENABLE: enable          <= wdata[NVEC-1:0];
        OFF_MASK:   mask            <= wdata[NVEC-1:0];
        default: ;
      endcase
    end
  end

  assign clr_vec = (wr_en && addr == OFF_STATUS) ? wdata[NVEC-1:0] : '0;

  always_comb begin
    case (addr)
      OFF_TGT_LO: rd_mux = tgt_addr[31:0];
      OFF_TGT_HI: rd_mux = tgt_addr[63:32];
      OFF_ENABLE: rd_mux = REG_DW'(enable);
      OFF_MASK:   rd_mux = REG_DW'(mask);
      OFF_STATUS: rd_mux = REG_DW'(status);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/msi_doorbell.sv
module msi_doorbell
  import msi_pkg::*;
#(
  parameter int NVEC           = 32,
  parameter int DOORBELL_BYTES = 4
) (
  input  logic              snoop_valid,
  input  logic [TGT_AW-1:0] snoop_addr,
  input  logic [REG_DW-1:0] snoop_data,
  input  logic [2:0]        snoop_len,
  input  logic [TGT_AW-1:0] tgt_addr,
  input  logic [NVEC-1:0]   enable,
  output logic              hit,
  output logic [NVEC-1:0]   set_vec
);
  localparam int IDXW = (NVEC > 1) ? $clog2(NVEC) : 1;

  function automatic logic [NVEC-1:0] vector_onehot(input logic [REG_DW-1:0] d);
    logic [NVEC-1:0] one;
    one = {{(NVEC-1){1'b0}}, 1'b1};
    if (d < REG_DW'(NVEC)) return one << d[IDXW-1:0];
    return '0;
  endfunction

  assign hit = snoop_valid
            && is_doorbell_size(snoop_len, DOORBELL_BYTES)
            && (snoop_addr == tgt_addr)
            && (|enable);

  assign set_vec = hit ? (vector_onehot(snoop_data) & enable) : '0;
endmodule

// File: rtl/msi_status.sv
module msi_status #(
  parameter int NVEC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] set_vec,
  input  logic [NVEC-1:0] clr_vec,
  input  logic [NVEC-1:0] mask,
  output logic [NVEC-1:0] status,
  output logic            irq
);
  function automatic logic [NVEC-1:0] next_status(input logic [NVEC-1:0] cur,
                                                  input logic [NVEC-1:0] s,
                                                  input logic [NVEC-1:0] c);
    return (cur & ~c) | s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= next_status(status, set_vec, clr_vec);
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/msi_catcher.sv
module msi_catcher
  import msi_pkg::*;
#(
  parameter int NVEC           = 32,
  parameter int DOORBELL_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              snoop_valid,
  input  logic [TGT_AW-1:0] snoop_addr,
  input  logic [REG_DW-1:0] snoop_data,
  input  logic [2:0]        snoop_len,
  output logic              irq_o
);
  logic [TGT_AW-1:0] tgt_addr_w;
  logic [NVEC-1:0]   enable_w;
  logic [NVEC-1:0]   mask_w;
  logic [NVEC-1:0]   clr_vec_w;
  logic [NVEC-1:0]   set_vec_w;
  logic [NVEC-1:0]   status_w;
  logic              hit_w;

  msi_regfile #(.NVEC(NVEC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr), .wdata(reg_wdata),
    .status(status_w),
    .tgt_addr(tgt_addr_w), .enable(enable_w), .mask(mask_w),
    .clr_vec(clr_vec_w), .rdata(reg_rdata)
  );

  msi_doorbell #(.NVEC(NVEC), .DOORBELL_BYTES(DOORBELL_BYTES)) u_door (
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .snoop_data(snoop_data), .snoop_len(snoop_len),
    .tgt_addr(tgt_addr_w), .enable(enable_w),
    .hit(hit_w), .set_vec(set_vec_w)
  );

  msi_status #(.NVEC(NVEC)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_vec(set_vec_w), .clr_vec(clr_vec_w), .mask(mask_w),
    .status(status_w), .irq(irq_o)
  );
endmodule

// File: rtl/msi_catcher_chk.sv
module msi_catcher_chk
  import msi_pkg::*;
#(
  parameter int NVEC = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic              snoop_valid,
  input logic [2:0]        snoop_len,
  input logic              hit,
  input logic [TGT_AW-1:0] tgt_addr,
  input logic [NVEC-1:0]   enable,
  input logic [NVEC-1:0]   set_vec,
  input logic [NVEC-1:0]   clr_vec,
  input logic [NVEC-1:0]   status,
  input logic              irq_o
);
  // R2: a low-half write keeps the high half
  a_r2_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFF_TGT_LO) |=> $stable(tgt_addr[63:32]));

  // R2: a high-half write keeps the low half
  a_r2_lo_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFF_TGT_HI) |=> $stable(tgt_addr[31:0]));

  // R3: a newly set status bit had its enable bit on
  a_r3_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(enable)) == '0));

  // R5: no pending status means no interrupt
  a_r5_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq_o);

  // R6: an all-zero enable blocks the doorbell
  a_r6_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> (set_vec == '0 && !hit));

  // R7: wrong-size writes never set a vector
  a_r7_size_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_len != 3'd4) |-> (set_vec == '0));

  // R9: set beats clear on the same bit
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  // R8 / R3: at most one vector set per doorbell
  a_r8_single_vector: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
endmodule

bind msi_catcher msi_catcher_chk #(.NVEC(NVEC)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .snoop_valid(snoop_valid), .snoop_len(snoop_len),
  .hit(hit_w), .tgt_addr(tgt_addr_w), .enable(enable_w),
  .set_vec(set_vec_w), .clr_vec(clr_vec_w), .status(status_w),
  .irq_o(irq_o)
);

// File: tb/tb_msi_catcher.sv
module tb_msi_catcher;
  import msi_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        snoop_valid = 1'b0;
  logic [63:0] snoop_addr = '0;
  logic [31:0] snoop_data = '0;
  logic [2:0]  snoop_len = '0;
  logic        irq_o;

  always #2 clk = ~clk;

  msi_catcher dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .snoop_data(snoop_data), .snoop_len(snoop_len), .irq_o(irq_o)
  );

  int errors = 0;
  int checks = 0;

  // bench model, updated from the requirements
  logic [63:0] m_tgt = '0;
  logic [31:0] m_en = '0;
  logic [31:0] m_mask = '0;
  logic [31:0] m_status = '0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb[$];
  logic rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= reg_rd_en;

  // monitor: read data is due at the falling edge after the sampling edge
  always @(negedge clk) begin
    if (rd_seen && sb.size() > 0) begin
      rd_item_t it;
      it = sb.pop_front();
      checks++;
      if (reg_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    case (a)
      OFF_TGT_LO: m_tgt[31:0]  = d;
      OFF_TGT_HI: m_tgt[63:32] = d;
      OFF_ENABLE: m_en   = d;
      OFF_MASK:   m_mask = d;
      OFF_STATUS: m_status = m_status & ~d;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_set(input logic [63:0] a, input logic [31:0] d,
                                            input logic [2:0] len);
    if (a == m_tgt && len == 3'd4 && m_en != 0 && d < 32 && m_en[d[4:0]])
      return 32'h1 << d[4:0];
    return '0;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      OFF_TGT_LO: return m_tgt[31:0];
      OFF_TGT_HI: return m_tgt[63:32];
      OFF_ENABLE: return m_en;
      OFF_MASK:   return m_mask;
      OFF_STATUS: return m_status;
      default:    return '0;
    endcase
  endfunction

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    model_write(a, d);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, input string tag);
    rd_item_t it;
    it.exp = model_read(a);
    it.tag = tag;
    sb.push_back(it);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic doorbell(input logic [63:0] a, input logic [31:0] d, input logic [2:0] len);
    snoop_valid = 1'b1; snoop_addr = a; snoop_data = d; snoop_len = len;
    m_status = m_status | model_set(a, d, len);
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  // doorbell and status clear in one cycle
  task automatic doorbell_and_clear(input logic [31:0] d, input logic [31:0] clr);
    logic [31:0] s;
    s = model_set(m_tgt, d, 3'd4);
    snoop_valid = 1'b1; snoop_addr = m_tgt; snoop_data = d; snoop_len = 3'd4;
    reg_wr_en = 1'b1; reg_addr = OFF_STATUS; reg_wdata = clr;
    m_status = (m_status & ~clr) | s;
    @(negedge clk);
    snoop_valid = 1'b0; reg_wr_en = 1'b0;
  endtask

  task automatic check_irq(input string tag);
    logic e;
    e = |(m_status & ~m_mask);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq_o=%b expected=%b", tag, irq_o, e);
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check_irq("R10 irq after reset");
    reg_read(OFF_TGT_LO, "R10 addr lo");
    reg_read(OFF_TGT_HI, "R10 addr hi");
    reg_read(OFF_ENABLE, "R10 enable");
    reg_read(OFF_MASK,   "R10 mask");
    reg_read(OFF_STATUS, "R10 status");

    // R1 / R2: address halves
    reg_write(OFF_TGT_LO, 32'hFEE0_0040);
    reg_write(OFF_TGT_HI, 32'h0000_0001);
    reg_read(OFF_TGT_LO, "R1 addr lo readback");
    reg_read(OFF_TGT_HI, "R1 addr hi readback");
    reg_write(OFF_TGT_LO, 32'hFEE0_0080);
    reg_read(OFF_TGT_HI, "R2 hi kept after lo write");
    reg_write(OFF_TGT_HI, 32'h0000_0002);
    reg_read(OFF_TGT_LO, "R2 lo kept after hi write");

    // R6: closed window
    doorbell(m_tgt, 32'd3, 3'd4);
    reg_read(OFF_STATUS, "R6 no set with enable zero");
    check_irq("R6 irq stays low");

    // R3: enabled and disabled vectors
    reg_write(OFF_ENABLE, 32'h0000_00F0);
    doorbell(m_tgt, 32'd5, 3'd4);
    check_irq("R4 irq after vector 5");
    reg_read(OFF_STATUS, "R3 vector 5 set");
    doorbell(m_tgt, 32'd2, 3'd4);
    reg_read(OFF_STATUS, "R3 disabled vector 2 ignored");

    // R11 / R7: address and size gates
    doorbell(m_tgt + 64'd4, 32'd6, 3'd4);
    reg_read(OFF_STATUS, "R11 other address ignored");
    doorbell(m_tgt, 32'd6, 3'd2);
    reg_read(OFF_STATUS, "R7 two-byte write ignored");
    doorbell(m_tgt, 32'd7, 3'd0);
    reg_read(OFF_STATUS, "R7 zero-size write ignored");

    // R8: data out of range
    reg_write(OFF_ENABLE, 32'hFFFF_FFFF);
    doorbell(m_tgt, 32'd32, 3'd4);
    reg_read(OFF_STATUS, "R8 data 32 ignored");
    doorbell(m_tgt, 32'hFFFF_FFFF, 3'd4);
    reg_read(OFF_STATUS, "R8 all-ones data ignored");
    doorbell(m_tgt, 32'd31, 3'd4);
    reg_read(OFF_STATUS, "R3 top vector 31 set");

    // R4: mask blocks irq, not capture
    reg_write(OFF_MASK, 32'h8000_0020);
    check_irq("R4 all pending masked");
    reg_read(OFF_MASK, "R1 mask readback");
    reg_read(OFF_ENABLE, "R1 enable readback");
    reg_write(OFF_ENABLE, 32'h0000_0010);
    doorbell(m_tgt, 32'd4, 3'd4);
    check_irq("R4 unmasked vector 4 raises irq");
    reg_read(OFF_STATUS, "R4 status captured under mask");

    // R5: write-one-to-clear
    reg_write(OFF_MASK, 32'h0);
    reg_write(OFF_STATUS, 32'h0000_0030);
    check_irq("R5 irq with bit 31 left");
    reg_read(OFF_STATUS, "R5 partial clear");
    reg_write(OFF_STATUS, 32'h8000_0000);
    check_irq("R5 irq low when status clear");
    reg_read(OFF_STATUS, "R5 status empty");

    // R9: set wins over clear
    reg_write(OFF_ENABLE, 32'h0000_0202);
    doorbell(m_tgt, 32'd1, 3'd4);
    doorbell_and_clear(32'd9, 32'h0000_0202);
    reg_read(OFF_STATUS, "R9 set kept, other bit cleared");
    check_irq("R9 irq after race");
    doorbell_and_clear(32'd9, 32'h0000_0200);
    reg_read(OFF_STATUS, "R9 repeated race keeps bit");
    reg_write(OFF_STATUS, 32'hFFFF_FFFF);
    check_irq("R5 irq low after full clear");

    // R1: unmapped offset
    reg_read(12'h834, "R1 unmapped reads zero");

    drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule